// File: doc/BRIEF.md
# Cluster Request Sequencer

This block sits on the external-agent side of a processor system interface running with a secondary cache. It follows request clusters. A cluster opens with one processor read and is followed by one or two more requests that the processor issues while that read is still pending. The block records which members the open cluster still owes. The first is a write, when the read carried the write-forthcoming bit. The second is a null write, when an intervening external request cleaned the line that was to be written back. The third is a potential update, when potential updates are enabled. The block holds back the read response until every member has been accepted.

The response data path is outside this block. The agent presents response beats on `rsp_beat`, and the block accepts them only while `rsp_grant` is high. A beat presented too early is refused and raises a one-cycle violation pulse. The final accepted beat closes the cluster and reports completion, together with a bus-error indication if any accepted beat carried an error flag. An update seen while the read is pending is held as potential until the read completes.

Top module: `clu_seq`

## Requirements
- R1: After reset, `clu_open`, `write_owed`, `null_owed`, `pupd_expected`, `pupd_live`, `rsp_grant`, `violation`, `rd_done` and `bus_err` are all 0.
- R2: A request with `req_kind`=0 (read) and `req_wfw`=1, seen while no cluster is open, sets `clu_open` and `write_owed` one cycle later.
- R3: A read that opens a cluster sets `pupd_expected` one cycle later exactly when `cfg_pupd_en` is 1 at that read. It stays 0 when `cfg_pupd_en` is 0.
- R4: `rsp_grant` is 1 only while a cluster is open and no write, null write or expected update is outstanding. A read with `req_wfw`=0 and `cfg_pupd_en`=0 gives `rsp_grant`=1 in the next cycle.
- R5: A request with `req_kind`=1 (write) while `write_owed` is 1 clears `write_owed` one cycle later.
- R6: A cycle with `ext_done`=1 and `ext_clean`=1 while `write_owed` is 1 clears `write_owed` and sets `null_owed` one cycle later. `ext_done` with `ext_clean`=0 changes nothing. A request with `req_kind`=2 (null write) clears `null_owed`.
- R7: A request with `req_kind`=3 (update) while a cluster is open sets `pupd_live` and clears `pupd_expected` one cycle later. `pupd_live` stays 1 across non-final beats and drops in the cycle `rd_done` rises. An update while no cluster is open leaves `pupd_live` at 0.
- R8: A beat presented while `rsp_grant` is 0 is not accepted. It produces `violation`=1 for one cycle, one cycle later, and the cluster stays open.
- R9: A beat accepted with `rsp_last`=1 gives `rd_done`=1 for one cycle, one cycle later, with `clu_open` back at 0. A beat accepted with `rsp_last`=0 leaves the cluster open and `rd_done` at 0.
- R10: `bus_err` is 1 in the `rd_done` cycle exactly when some accepted beat of that read carried `rsp_err`=1. The error record is cleared for the next read.
- R11: Write and update requests while no cluster is open change no cluster state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pupd_en | input | 1 | Potential updates within a cluster enabled |
| req_valid | input | 1 | A processor request is accepted this cycle |
| req_kind | input | 2 | 0 read, 1 write, 2 null write, 3 update |
| req_wfw | input | 1 | Write-forthcoming bit of a read |
| ext_done | input | 1 | An external request completes this cycle |
| ext_clean | input | 1 | That external request moved the write-back line out of a dirty state |
| rsp_beat | input | 1 | Agent presents a response word |
| rsp_last | input | 1 | Presented word is the final one |
| rsp_err | input | 1 | Presented word carries an error flag |
| rsp_grant | output | 1 | Response may be transferred |
| clu_open | output | 1 | A cluster read is pending |
| write_owed | output | 1 | A write member is still owed |
| null_owed | output | 1 | A null write member is still owed |
| pupd_expected | output | 1 | A potential update member is still owed |
| pupd_live | output | 1 | A potential update was received and is still potential |
| violation | output | 1 | Pulse: a beat was refused |
| rd_done | output | 1 | Pulse: read completed |
| bus_err | output | 1 | Pulse with rd_done: read data was erroneous |

## Verification
All state flags, including the violation, completion and error pulses, are registered. Each of them changes at the first rising edge after the stimulus. `rsp_grant` is combinational from those flags, so it follows the same edge. The bench drives every input just after a falling edge. It then waits for the next falling edge and samples there, half a period after the edge that carries the result, and checks pulses in that single window.

// File: rtl/clu_seq_pkg.sv
package clu_seq_pkg;
   typedef enum logic [1:0] {
      RQ_READ   = 2'd0,
      RQ_WRITE  = 2'd1,
      RQ_NULLWR = 2'd2,
      RQ_UPDATE = 2'd3
   } rq_kind_e;

   typedef struct packed {
      logic open;
      logic wr_owed;
      logic nul_owed;
      logic pu_exp;
      logic pu_live;
   } clu_state_t;
endpackage

// File: rtl/clu_track.sv
module clu_track
   import clu_seq_pkg::*;
#(
   parameter int PUPD_SUPPORT = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_pupd_en,
   input  logic       req_valid,
   input  rq_kind_e   req_kind,
   input  logic       req_wfw,
   input  logic       ext_done,
   input  logic       ext_clean,
   input  logic       close,
   output clu_state_t st,
   output logic       complete
);
   localparam bit PU_ON = (PUPD_SUPPORT != 0);

   if (PUPD_SUPPORT != 0 && PUPD_SUPPORT != 1) begin : g_bad_pu
      $error("PUPD_SUPPORT must be 0 or 1");
   end

   clu_state_t st_q, st_d;
   logic       is_rd, is_wr, is_nw, is_up;

   always_comb begin
      is_rd = req_valid && (req_kind == RQ_READ);
      is_wr = req_valid && (req_kind == RQ_WRITE);
      is_nw = req_valid && (req_kind == RQ_NULLWR);
      is_up = req_valid && (req_kind == RQ_UPDATE);
   end

   always_comb begin
      st_d = st_q;
      if (!st_q.open) begin
         if (is_rd) begin
            st_d.open     = 1'b1;
            st_d.wr_owed  = req_wfw;
            st_d.nul_owed = 1'b0;
            st_d.pu_exp   = PU_ON && cfg_pupd_en;
            st_d.pu_live  = 1'b0;
         end
      end else if (close) begin
         st_d = '0;
      end else begin
         if (is_wr && st_q.wr_owed) st_d.wr_owed = 1'b0;
         if (ext_done && ext_clean && st_q.wr_owed && !is_wr) begin
            st_d.wr_owed  = 1'b0;
            st_d.nul_owed = 1'b1;
         end
         if (is_nw && st_q.nul_owed) st_d.nul_owed = 1'b0;
         if (is_up && PU_ON) begin
            st_d.pu_live = 1'b1;
            st_d.pu_exp  = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_d;
   end

   assign st       = st_q;
   assign complete = st_q.open && !st_q.wr_owed && !st_q.nul_owed && !st_q.pu_exp;

   AST_WFW_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && req_wfw && !st_q.open) |=> (st_q.open && st_q.wr_owed)); // R2
   AST_NULL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q.nul_owed) |-> $past(ext_done && ext_clean)); // R6
   AST_LIVE_IN_CLUSTER: assert property (@(posedge clk) disable iff (!rst_n)
      st_q.pu_live |-> st_q.open); // R7
   AST_IDLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_q.open && !is_rd) |=> !st_q.open); // R11
endmodule

// File: rtl/clu_rsp_gate.sv
module clu_rsp_gate #(
   parameter int VIOL_STICKY = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic open,
   input  logic complete,
   input  logic rsp_beat,
   input  logic rsp_last,
   input  logic rsp_err,
   output logic close,
   output logic violation,
   output logic rd_done,
   output logic bus_err
);
   if (VIOL_STICKY != 0 && VIOL_STICKY != 1) begin : g_bad_vs
      $error("VIOL_STICKY must be 0 or 1");
   end

   logic take, refuse, err_acc;

   assign take   = rsp_beat && complete;
   assign refuse = rsp_beat && !complete;
   assign close  = take && rsp_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_done <= 1'b0;
         bus_err <= 1'b0;
         err_acc <= 1'b0;
      end else begin
         rd_done <= close;
         bus_err <= close && (err_acc || rsp_err);
         if (close)                err_acc <= 1'b0;
         else if (take && rsp_err) err_acc <= 1'b1;
      end
   end

   if (VIOL_STICKY == 1) begin : g_sticky
      always_ff @(posedge clk) begin
         if (!rst_n)     violation <= 1'b0;
         else if (close) violation <= 1'b0;
         else if (refuse) violation <= 1'b1;
      end
   end else begin : g_pulse
      always_ff @(posedge clk) begin
         if (!rst_n) violation <= 1'b0;
         else        violation <= refuse;
      end
   end

   AST_DONE_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |-> $past(complete && rsp_beat)); // R9
   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> rd_done); // R10
   AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |-> !open); // R9
endmodule

// File: rtl/clu_seq.sv
module clu_seq
   import clu_seq_pkg::*;
#(
   parameter int PUPD_SUPPORT = 1,
   parameter int VIOL_STICKY  = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_pupd_en,
   input  logic       req_valid,
   input  logic [1:0] req_kind,
   input  logic       req_wfw,
   input  logic       ext_done,
   input  logic       ext_clean,
   input  logic       rsp_beat,
   input  logic       rsp_last,
   input  logic       rsp_err,
   output logic       rsp_grant,
   output logic       clu_open,
   output logic       write_owed,
   output logic       null_owed,
   output logic       pupd_expected,
   output logic       pupd_live,
   output logic       violation,
   output logic       rd_done,
   output logic       bus_err
);
   clu_state_t st;
   logic       complete, close;

   clu_track #(.PUPD_SUPPORT(PUPD_SUPPORT)) u_track (
      .clk(clk), .rst_n(rst_n), .cfg_pupd_en(cfg_pupd_en),
      .req_valid(req_valid), .req_kind(rq_kind_e'(req_kind)), .req_wfw(req_wfw),
      .ext_done(ext_done), .ext_clean(ext_clean), .close(close),
      .st(st), .complete(complete)
   );

   clu_rsp_gate #(.VIOL_STICKY(VIOL_STICKY)) u_gate (
      .clk(clk), .rst_n(rst_n), .open(st.open), .complete(complete),
      .rsp_beat(rsp_beat), .rsp_last(rsp_last), .rsp_err(rsp_err),
      .close(close), .violation(violation), .rd_done(rd_done), .bus_err(bus_err)
   );

   assign rsp_grant     = complete;
   assign clu_open      = st.open;
   assign write_owed    = st.wr_owed;
   assign null_owed     = st.nul_owed;
   assign pupd_expected = st.pu_exp;
   assign pupd_live     = st.pu_live;

   AST_REFUSED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_beat && clu_open && !rsp_grant) |=> clu_open); // R8
   AST_GRANT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_grant |-> clu_open); // R4
endmodule

// File: tb/clu_seq_tb.sv
module clu_seq_tb;
   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_pupd_en = 0, req_valid = 0, req_wfw = 0, ext_done = 0, ext_clean = 0;
   logic [1:0] req_kind = 0;
   logic rsp_beat = 0, rsp_last = 0, rsp_err = 0;
   logic rsp_grant, clu_open, write_owed, null_owed, pupd_expected, pupd_live;
   logic violation, rd_done, bus_err;
   int n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   clu_seq u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_pupd_en(cfg_pupd_en), .req_valid(req_valid),
      .req_kind(req_kind), .req_wfw(req_wfw), .ext_done(ext_done), .ext_clean(ext_clean),
      .rsp_beat(rsp_beat), .rsp_last(rsp_last), .rsp_err(rsp_err),
      .rsp_grant(rsp_grant), .clu_open(clu_open), .write_owed(write_owed),
      .null_owed(null_owed), .pupd_expected(pupd_expected), .pupd_live(pupd_live),
      .violation(violation), .rd_done(rd_done), .bus_err(bus_err)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      req_valid = 0; req_kind = 0; req_wfw = 0; ext_done = 0; ext_clean = 0;
      rsp_beat = 0; rsp_last = 0; rsp_err = 0;
   endtask

   // drive after a falling edge, then sample at the next falling edge
   task automatic step();
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic req(input logic [1:0] k, input logic wfw);
      req_valid = 1; req_kind = k; req_wfw = wfw;
      step();
   endtask

   task automatic beat(input logic last, input logic err);
      rsp_beat = 1; rsp_last = last; rsp_err = err;
      step();
   endtask

   task automatic t_reset();
      chk("R1 open", clu_open, 0);        chk("R1 wr", write_owed, 0);
      chk("R1 nul", null_owed, 0);        chk("R1 pexp", pupd_expected, 0);
      chk("R1 plive", pupd_live, 0);      chk("R1 grant", rsp_grant, 0);
      chk("R1 viol", violation, 0);       chk("R1 done", rd_done, 0);
      chk("R1 berr", bus_err, 0);
   endtask

   task automatic t_plain_read();
      cfg_pupd_en = 0;
      req(2'd0, 0);
      chk("R4 open", clu_open, 1);
      chk("R3 no pexp", pupd_expected, 0);
      chk("R4 grant", rsp_grant, 1);
      beat(1, 0);
      chk("R9 done", rd_done, 1);
      chk("R9 closed", clu_open, 0);
      chk("R10 no berr", bus_err, 0);
      step();
      chk("R9 pulse", rd_done, 0);
   endtask

   task automatic t_write_cluster();
      cfg_pupd_en = 1;
      req(2'd0, 1);
      chk("R2 open", clu_open, 1);
      chk("R2 wr", write_owed, 1);
      chk("R3 pexp", pupd_expected, 1);
      chk("R4 no grant", rsp_grant, 0);
      beat(1, 0);
      chk("R8 viol", violation, 1);
      chk("R8 open", clu_open, 1);
      chk("R8 no done", rd_done, 0);
      req(2'd1, 0);
      chk("R5 wr clr", write_owed, 0);
      chk("R8 viol pulse", violation, 0);
      chk("R4 still no grant", rsp_grant, 0);
      req(2'd3, 0);
      chk("R7 live", pupd_live, 1);
      chk("R7 exp clr", pupd_expected, 0);
      chk("R4 grant", rsp_grant, 1);
      beat(0, 1);
      chk("R9 mid open", clu_open, 1);
      chk("R9 mid done", rd_done, 0);
      chk("R7 live kept", pupd_live, 1);
      beat(1, 0);
      chk("R9 done", rd_done, 1);
      chk("R10 berr", bus_err, 1);
      chk("R7 live drop", pupd_live, 0);
      cfg_pupd_en = 0;
   endtask

   task automatic t_null_cluster();
      cfg_pupd_en = 0;
      req(2'd0, 1);
      chk("R2 wr", write_owed, 1);
      ext_done = 1; ext_clean = 0;
      step();
      chk("R6 no clean", write_owed, 1);
      chk("R6 no null", null_owed, 0);
      ext_done = 1; ext_clean = 1;
      step();
      chk("R6 wr clr", write_owed, 0);
      chk("R6 null set", null_owed, 1);
      chk("R4 no grant", rsp_grant, 0);
      req(2'd2, 0);
      chk("R6 null clr", null_owed, 0);
      chk("R4 grant", rsp_grant, 1);
      beat(1, 0);
      chk("R9 done", rd_done, 1);
      chk("R10 err cleared", bus_err, 0);
   endtask

   task automatic t_idle_ignore();
      req(2'd1, 0);
      chk("R11 write idle", clu_open, 0);
      chk("R11 write idle wr", write_owed, 0);
      req(2'd3, 0);
      chk("R7 update idle", pupd_live, 0);
      chk("R11 update idle", clu_open, 0);
   endtask

   initial begin : wdog
      repeat (5000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      idle_inputs();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_plain_read();
      t_write_cluster();
      t_null_cluster();
      t_idle_ignore();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule